// File: doc/BRIEF.md
# Checker L1 Volatile-Line Tracker

A checker core in a redundant-execution scheme re-runs the lead core's instruction stream chunk by chunk, and several checkers share the chunks between them. A checker's private L1 data cache can therefore hold lines that a chunk it never executes will change. This block keeps the tag-side state for that cache: a valid bit, a tag and a volatile bit for every line of a 2-way set-associative array with 32-byte lines. The volatile bit means "a later chunk writes this line". It is set in two ways. The first is a non-destructive hint from the lead core, which the lead sends on the first write to a line within a chunk. The second is a fill whose forward search of the unverified-store buffer reports a future writer.

The volatile bit does not remove the line while the checker runs chunks in order. When the checker is given a chunk that does not directly follow the one it last took, the chunks in between were skipped, and any volatile line may now be stale. A sweep sequencer then walks the array one set per cycle and invalidates every volatile line. The sweep leaves non-volatile lines in place. While the sweep runs the block refuses fills and new chunk assignments. A combinational probe port returns the per-way state of any set and a hit indication, and the cache pipeline uses it.

The sweep sequencer has two states. In SW_IDLE the array serves hints, fills and probes. The transition GO_SWEEP (a non-successor chunk assignment) leads to SW_RUN, which visits sets 0 to SETS-1 in order. The transition SWEEP_DONE (last set visited) returns to SW_IDLE.

Top module: `vt_volatile_tracker`

## Requirements
- R1: After reset every line reads invalid and not volatile, `sweep_busy` is low and `fill_ready` is high.
- R2: An address splits into a byte offset in bits [4:0], which the block ignores, a set index in bits [IDX_W+4:5], and a tag in the bits above. A fill accepted at a clock edge writes valid=1, the fill tag and volatile=`fill_future` into way `fill_way` of its set, and the probe shows it after that edge.
- R3: A hint (`qinv_valid`) whose tag matches a valid way of its set sets that way's volatile bit and leaves the line valid with its tag unchanged.
- R4: A hint whose tag matches no valid way of its set changes no state.
- R5: The first chunk assignment after reset, and any assignment whose id equals the previous id plus one modulo 2^CHUNK_W (255 is followed by 0 at the default width), starts no sweep and keeps every volatile bit.
- R6: Any other accepted chunk id (a jump forward, backward, or a repeat of the same id) raises `sweep_busy` from the next cycle for exactly SETS cycles. After the sweep every line that was volatile is invalid and not volatile, and every other line is unchanged.
- R7: While `sweep_busy` is high, `fill_ready` is low, and fills and chunk assignments presented then are ignored. An ignored assignment does not become the previous id.
- R8: The probe returns, for the set of `probe_addr`, the valid and volatile bit of each way (bit w = way w), and `probe_hit`/`probe_hit_way` for a valid way whose tag matches.
- R9: No line is ever volatile while invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| qinv_valid | input | 1 | Volatile hint from the lead core this cycle |
| qinv_addr | input | ADDR_W | Byte address of the hinted line |
| fill_valid | input | 1 | Line fill this cycle |
| fill_addr | input | ADDR_W | Byte address of the filled line |
| fill_way | input | WAY_W | Way the fill replaces |
| fill_future | input | 1 | Forward search found a later writer of the line |
| fill_ready | output | 1 | Fills are accepted (low during a sweep) |
| chunk_valid | input | 1 | New chunk assignment this cycle |
| chunk_id | input | CHUNK_W | Id of the assigned chunk |
| sweep_busy | output | 1 | Sweep in progress |
| probe_addr | input | ADDR_W | Address looked up by the probe |
| probe_valid | output | WAYS | Valid bit per way of the probed set |
| probe_vol | output | WAYS | Volatile bit per way of the probed set |
| probe_hit | output | 1 | A valid way of the probed set matches the tag |
| probe_hit_way | output | WAY_W | Way that matched |

## Verification
A wrong state in this block reaches the probe port on the edge after the event that caused it. Examples are a hint that invalidates instead of marking, a dropped miss that marks a line, or a fill that ignores the forward-search flag. A wrong gap decision shows as `sweep_busy` rising, or failing to rise, one cycle after the assignment. A wrong sweep length is visible in the count of busy cycles. A line cleared or kept wrongly by the sweep is visible on a full probe of every set as soon as busy falls. An assignment or fill leaking through during the sweep shows either in the array state or in the sweep decision for the next chunk.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/vt_chunk_seq.sv
module vt_chunk_seq #(
    parameter int CHUNK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chunk_valid,
    input  logic [CHUNK_W-1:0] chunk_id,
    input  logic               busy,
    output logic               sweep_start,
    output logic [CHUNK_W-1:0] last_id,
    output logic               have_id
);

    logic [CHUNK_W-1:0] last_q;
    logic               have_q;
    logic [CHUNK_W-1:0] succ_id;
    logic               accept;

    assign accept  = chunk_valid && !busy;
    assign succ_id = last_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            have_q <= 1'b0;
        end else if (accept) begin
            last_q <= chunk_id;
            have_q <= 1'b1;
        end
    end

    // a jump in either direction, or a repeat, means chunks were skipped
    assign sweep_start = accept && have_q && (chunk_id != succ_id);
    assign last_id     = last_q;
    assign have_id     = have_q;

endmodule

// File: rtl/vt_sweep_fsm.sv
module vt_sweep_fsm
    import vt_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             sweep_en,
    output logic [IDX_W-1:0] sweep_set
);

    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SW_IDLE: begin
                if (start) begin          // GO_SWEEP
                    state_d = SW_RUN;
                    idx_d   = '0;
                end
            end
            SW_RUN: begin
                if (idx_q == LAST_SET) begin   // SWEEP_DONE
                    state_d = SW_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = SW_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy      = (state_q == SW_RUN);
        sweep_en  = (state_q == SW_RUN);
        sweep_set = idx_q;
    end

endmodule

// File: rtl/vt_line_array.sv
module vt_line_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int TAG_W = 23,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        qinv_en,
    input  logic [IDX_W-1:0]            qinv_set,
    input  logic [TAG_W-1:0]            qinv_tag,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_set,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        fill_vol,
    input  logic                        sweep_en,
    input  logic [IDX_W-1:0]            sweep_set,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_vol,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  vol_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic             fill_here;

        assign fill_here = fill_en && (fill_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    valid_q[s] <= 1'b0;
                    vol_q[s]   <= 1'b0;
                    tag_q[s]   <= '0;
                end
            end else begin
                for (int s = 0; s < SETS; s++) begin
                    if (sweep_en && (sweep_set == IDX_W'(s)) && vol_q[s]) begin
                        valid_q[s] <= 1'b0;
                        vol_q[s]   <= 1'b0;
                    end else if (qinv_en && (qinv_set == IDX_W'(s)) &&
                                 valid_q[s] && (tag_q[s] == qinv_tag)) begin
                        vol_q[s] <= 1'b1;
                    end
                    // a fill replaces whatever the hint saw in this way
                    if (fill_here && (fill_set == IDX_W'(s))) begin
                        valid_q[s] <= 1'b1;
                        vol_q[s]   <= fill_vol;
                        tag_q[s]   <= fill_tag;
                    end
                end
            end
        end

        assign rd_valid[w] = valid_q[rd_set];
        assign rd_vol[w]   = vol_q[rd_set];
        assign rd_tag[w]   = tag_q[rd_set];
    end

endmodule

// File: rtl/vt_volatile_tracker.sv
module vt_volatile_tracker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 16,
    parameter int WAYS       = 2,
    parameter int CHUNK_W    = 8,
    parameter int WAY_W      = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               qinv_valid,
    input  logic [ADDR_W-1:0]  qinv_addr,
    input  logic               fill_valid,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [WAY_W-1:0]   fill_way,
    input  logic               fill_future,
    output logic               fill_ready,
    input  logic               chunk_valid,
    input  logic [CHUNK_W-1:0] chunk_id,
    output logic               sweep_busy,
    input  logic [ADDR_W-1:0]  probe_addr,
    output logic [WAYS-1:0]    probe_valid,
    output logic [WAYS-1:0]    probe_vol,
    output logic               probe_hit,
    output logic [WAY_W-1:0]   probe_hit_way
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]           qinv_set, fill_set, probe_set, sweep_set;
    logic [TAG_W-1:0]           qinv_tag, fill_tag, probe_tag;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic                       sweep_en, sweep_start, busy;
    logic [CHUNK_W-1:0]         chunk_last;
    logic                       chunk_have;
    logic                       unused_offsets;

    assign qinv_set  = qinv_addr[OFF_W +: IDX_W];
    assign qinv_tag  = qinv_addr[ADDR_W-1 -: TAG_W];
    assign fill_set  = fill_addr[OFF_W +: IDX_W];
    assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];
    assign probe_set = probe_addr[OFF_W +: IDX_W];
    assign probe_tag = probe_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{qinv_addr[OFF_W-1:0], fill_addr[OFF_W-1:0],
                              probe_addr[OFF_W-1:0]};

    vt_chunk_seq #(.CHUNK_W(CHUNK_W)) u_chunk (
        .clk        (clk),
        .rst_n      (rst_n),
        .chunk_valid(chunk_valid),
        .chunk_id   (chunk_id),
        .busy       (busy),
        .sweep_start(sweep_start),
        .last_id    (chunk_last),
        .have_id    (chunk_have)
    );

    vt_sweep_fsm #(.SETS(SETS), .IDX_W(IDX_W)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sweep_start),
        .busy     (busy),
        .sweep_en (sweep_en),
        .sweep_set(sweep_set)
    );

    vt_line_array #(
        .SETS (SETS),
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .IDX_W(IDX_W),
        .WAY_W(WAY_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .qinv_en  (qinv_valid),
        .qinv_set (qinv_set),
        .qinv_tag (qinv_tag),
        .fill_en  (fill_valid && !busy),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .fill_tag (fill_tag),
        .fill_vol (fill_future),
        .sweep_en (sweep_en),
        .sweep_set(sweep_set),
        .rd_set   (probe_set),
        .rd_valid (probe_valid),
        .rd_vol   (probe_vol),
        .rd_tag   (rd_tag)
    );

    always_comb begin
        probe_hit     = 1'b0;
        probe_hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (probe_valid[w] && (rd_tag[w] == probe_tag)) begin
                probe_hit     = 1'b1;
                probe_hit_way = WAY_W'(w);
            end
        end
    end

    assign sweep_busy = busy;
    assign fill_ready = !busy;

endmodule

// File: rtl/vt_volatile_tracker_chk.sv
module vt_volatile_tracker_chk #(
    parameter int SETS    = 16,
    parameter int WAYS    = 2,
    parameter int CHUNK_W = 8,
    parameter int IDX_W   = $clog2(SETS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sweep_busy,
    input logic [IDX_W-1:0]   sweep_idx,
    input logic               chunk_valid,
    input logic [CHUNK_W-1:0] chunk_id,
    input logic [CHUNK_W-1:0] chunk_last,
    input logic               chunk_have,
    input logic [WAYS-1:0]    probe_valid,
    input logic [WAYS-1:0]    probe_vol
);

    localparam int RUN_W = $clog2(SETS + 2);

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_run <= '0;
        else if (sweep_busy) busy_run <= busy_run + 1'b1;
        else                 busy_run <= '0;
    end

    // R9
    vol_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_vol & ~probe_valid) == '0);

    // R6
    sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |-> (busy_run < RUN_W'(SETS)));

    // R6
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_busy && $past(sweep_busy)) |-> (sweep_idx == $past(sweep_idx) + 1'b1));

    // R6
    sweep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_busy) |-> $past(chunk_valid));

    // R5
    succ_no_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !sweep_busy && chunk_have &&
         (chunk_id == CHUNK_W'(chunk_last + 1'b1))) |=> !sweep_busy);

endmodule

bind vt_volatile_tracker vt_volatile_tracker_chk #(
    .SETS   (SETS),
    .WAYS   (WAYS),
    .CHUNK_W(CHUNK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sweep_busy (sweep_busy),
    .sweep_idx  (sweep_set),
    .chunk_valid(chunk_valid),
    .chunk_id   (chunk_id),
    .chunk_last (chunk_last),
    .chunk_have (chunk_have),
    .probe_valid(probe_valid),
    .probe_vol  (probe_vol)
);

// File: tb/tb_vt_volatile_tracker.sv
module tb_vt_volatile_tracker;

    localparam int PERIOD  = 10;
    localparam int SETS    = 16;
    localparam int WAYS    = 2;
    localparam int CHUNK_W = 8;
    localparam int ADDR_W  = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               qinv_valid = 1'b0;
    logic [ADDR_W-1:0]  qinv_addr = '0;
    logic               fill_valid = 1'b0;
    logic [ADDR_W-1:0]  fill_addr = '0;
    logic [0:0]         fill_way = '0;
    logic               fill_future = 1'b0;
    logic               fill_ready;
    logic               chunk_valid = 1'b0;
    logic [CHUNK_W-1:0] chunk_id = '0;
    logic               sweep_busy;
    logic [ADDR_W-1:0]  probe_addr = '0;
    logic [WAYS-1:0]    probe_valid, probe_vol;
    logic               probe_hit;
    logic [0:0]         probe_hit_way;

    int checks = 0;
    int errors = 0;
    int m_valid [SETS][WAYS];
    int m_vol   [SETS][WAYS];
    int m_tag   [SETS][WAYS];

    always #(PERIOD/2) clk = ~clk;

    vt_volatile_tracker #(.SETS(SETS), .WAYS(WAYS), .CHUNK_W(CHUNK_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .qinv_valid(qinv_valid), .qinv_addr(qinv_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
        .fill_future(fill_future), .fill_ready(fill_ready),
        .chunk_valid(chunk_valid), .chunk_id(chunk_id), .sweep_busy(sweep_busy),
        .probe_addr(probe_addr), .probe_valid(probe_valid), .probe_vol(probe_vol),
        .probe_hit(probe_hit), .probe_hit_way(probe_hit_way)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(int tag, int set, int off);
        return ADDR_W'((tag << 9) | (set << 5) | off);
    endfunction

    task automatic check(string req, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int s = 0; s < SETS; s++) begin
            int ev, eo, eh, av, ao, ah;
            probe_addr = mk_addr(m_tag[s][0], s, 7);
            #1;
            ev = m_valid[s][1] * 2 + m_valid[s][0];
            eo = m_vol[s][1] * 2 + m_vol[s][0];
            eh = m_valid[s][0];
            av = int'(probe_valid);
            ao = int'(probe_vol);
            ah = int'(probe_hit);
            check(req, (av == ev) && (ao == eo) && (ah == eh) &&
                  (!eh || probe_hit_way == 1'b0),
                  (s << 12) | (av << 8) | (ao << 4) | ah,
                  (s << 12) | (ev << 8) | (eo << 4) | eh);
        end
    endtask

    task automatic do_fill(int set, int way, int tag, int fut);
        @(negedge clk);
        fill_valid  = 1'b1;
        fill_addr   = mk_addr(tag, set, 3);
        fill_way    = 1'(way);
        fill_future = 1'(fut);
        m_valid[set][way] = 1;
        m_vol[set][way]   = fut;
        m_tag[set][way]   = tag;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_qinv(int set, int tag, int off);
        @(negedge clk);
        qinv_valid = 1'b1;
        qinv_addr  = mk_addr(tag, set, off);
        for (int w = 0; w < WAYS; w++)
            if (m_valid[set][w] != 0 && m_tag[set][w] == tag) m_vol[set][w] = 1;
        @(negedge clk);
        qinv_valid = 1'b0;
    endtask

    task automatic do_chunk(int id, int expect_sweep, int disturb, string req);
        int n = 0;
        @(negedge clk);
        chunk_valid = 1'b1;
        chunk_id    = CHUNK_W'(id);
        @(negedge clk);
        chunk_valid = 1'b0;
        while (sweep_busy && n < 100) begin
            n++;
            if (n == 1 && disturb != 0) begin
                // R7: fill into set 0 way 0 and a chunk assignment, both ignored
                fill_valid  = 1'b1;
                fill_addr   = mk_addr(85, 0, 0);
                fill_way    = 1'b0;
                fill_future = 1'b0;
                chunk_valid = 1'b1;
                chunk_id    = CHUNK_W'(20);
                check("R7 fill_ready low", fill_ready == 1'b0, int'(fill_ready), 0);
            end
            @(negedge clk);
            fill_valid  = 1'b0;
            chunk_valid = 1'b0;
        end
        check(req, n == (expect_sweep != 0 ? SETS : 0), n, expect_sweep != 0 ? SETS : 0);
        if (expect_sweep != 0)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (m_vol[s][w] != 0) begin
                        m_valid[s][w] = 0;
                        m_vol[s][w]   = 0;
                    end
        check_all(req);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_vol[s][w] = 0; m_tag[s][w] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy/ready", !sweep_busy && fill_ready, {sweep_busy, fill_ready}, 1);
        check_all("R1 lines clear");

        // R2 fill every line, volatile pattern from the set/way numbers
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                do_fill(s, w, s * 2 + w + 1, ((s + w) % 3 == 0) ? 1 : 0);
        check_all("R2 fill and R8 probe");

        // R3 hints that hit way 0 of even sets, with nonzero offsets
        for (int s = 0; s < SETS; s += 2) do_qinv(s, s * 2 + 1, s + 1);
        // R3 hints that hit way 1 of sets 5 and 7
        do_qinv(5, 12, 31);
        do_qinv(7, 16, 0);
        check_all("R3 hint marks, line kept");

        // R4 hints that miss
        for (int s = 1; s < SETS; s += 3) do_qinv(s, 32'h7FFF00 + s, 4);
        do_qinv(3, 1, 0);
        check_all("R4 miss dropped");

        // R5 first assignment and successor: no sweep
        do_chunk(5, 0, 0, "R5 first chunk no sweep");
        do_chunk(6, 0, 0, "R5 successor keeps volatile");

        // R6 forward jump sweeps; R7 disturbance during it
        do_chunk(8, 1, 1, "R6 jump sweep");
        do_chunk(9, 0, 0, "R7 ignored chunk not recorded");

        // refill and mark some lines, then jump back
        do_fill(0, 0, 40, 1);
        do_fill(1, 1, 41, 0);
        do_qinv(1, 41, 2);
        do_fill(4, 0, 42, 0);
        check_all("R2 refill");
        do_chunk(3, 1, 0, "R6 backward jump sweep");

        // R5 wrap of the chunk id
        do_chunk(255, 1, 0, "R6 jump to 255");
        do_fill(2, 0, 50, 1);
        do_chunk(0, 0, 0, "R5 wrap 255 to 0");

        // R6 repeat of same id sweeps
        do_chunk(0, 1, 0, "R6 repeated id sweep");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule